// File: doc/BRIEF.md
# Half-Bridge Gate-Drive Sequencer

This block turns a power controller's switching command and its mode select into the two gate enables of one synchronous buck phase. It drives one enable for the high-side switch and one for the low-side switch. Both command inputs are three-level signals that arrive already decoded into two-bit codes. The switching command selects high side on, low side on, or "no command". The mode select picks forced-PWM switching, pulse skipping, or deep standby. A midlevel on the switching command that lasts longer than a hold time parks the phase with both gates off. A midlevel on the mode select that lasts longer than the standby delay puts the phase into standby. Leaving standby costs a long wake-up delay.

Every enable transition uses break-before-make. A gate may switch on only after the opposite gate's "gate is off" flag reports off, and only after both enables have been low for a minimum number of cycles. In skip mode, a zero-cross flag ends the low-side pulse. The flag is honoured only after a blanking time measured from the start of the low-side interval. A supply-undervoltage flag and an over-temperature flag both force the gates off. All asynchronous inputs pass through synchronizers, and every time is a parameter counted in cycles of the block clock. A three-bit state output shows the operating state at any moment.

Top module: `hb_phase_seq`

The FSM states are FAULT, DISABLED, STANDBY, WAKING, FPWM and SKIP. Fault entry has priority over every other transition. The named transitions are:
- FAULT→FPWM/SKIP on fault release.
- FAULT→STANDBY when the standby delay has already expired.
- FPWM↔SKIP on a change of mode.
- FPWM/SKIP→DISABLED when the command hold expires.
- DISABLED→FPWM/SKIP when the command leaves midlevel.
- FPWM/SKIP/DISABLED→STANDBY when the standby delay expires.
- STANDBY→WAKING when both inputs leave midlevel.
- WAKING→STANDBY when the mode returns to midlevel.
- WAKING→FPWM/SKIP when the wake delay expires.

## Requirements
- R1: While reset is asserted, both enables are low and the state output reads FAULT (code 0).
- R2: In FPWM, a high command (code 10) makes `hs_en` high and `ls_en` low. A low command (code 00) makes `ls_en` high and `hs_en` low for the whole low interval.
- R3: `hs_en` and `ls_en` are never high together. An enable rises only when the opposite gate's off flag reports off, and only after both enables have been low for at least `DEAD_MIN_CYC` cycles.
- R4: A midlevel command held for `MID_HOLD_CYC` synchronized cycles moves the block to DISABLED with both enables low. A shorter midlevel keeps the previous drive. When the command returns to high or low, switching resumes in the next cycle, with no delay beyond the synchronizer.
- R5: In SKIP with the command low, an accepted zero-cross flag drops `ls_en`. The low side then stays off until the command goes high.
- R6: A zero-cross flag is ignored until `ZC_BLANK_CYC` cycles of the current low interval have passed.
- R7: A midlevel mode select held for `SBY_HOLD_CYC` cycles enters STANDBY with both enables low. The switching command is ignored there.
- R8: STANDBY is left only when both the mode select and the command are high or low. The block then spends `WAKE_CYC` cycles in WAKING with both gates off, and switching resumes only after that.
- R9: While `uv_flag` or `ot_flag` is set, the state is FAULT and both enables are low. On release with a low command, the low side is driven on and the high side stays off.
- R10: The state codes are FAULT=0, DISABLED=1, STANDBY=2, WAKING=3, FPWM=4 and SKIP=5. Input code 00 is low and 10 is high. Codes 01 and 11 are both midlevel. A mode select of 10 selects FPWM and 00 selects SKIP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_lvl | input | 2 | Decoded switching command (00 low, 10 high, else midlevel) |
| mode_lvl | input | 2 | Decoded mode select (00 skip, 10 forced PWM, else midlevel) |
| hs_off_fb | input | 1 | High-side gate reports off |
| ls_off_fb | input | 1 | Low-side gate reports off |
| zc_flag | input | 1 | Inductor current zero-cross detected |
| uv_flag | input | 1 | Supply undervoltage |
| ot_flag | input | 1 | Over-temperature |
| hs_en | output | 1 | High-side gate enable |
| ls_en | output | 1 | Low-side gate enable |
| state_o | output | 3 | Current operating state code |

## Verification
Two functions can fall in the same cycle. A fault flag and a switching-command edge can arrive together, and a fault can also coincide with the expiry of the standby delay. In each case the fault must win, and no gate may glitch on. The bench provokes both collisions by changing the inputs on the same clock edge and by raising a fault at the cycle where the standby timer is due to expire. A behavioural model, fed the same synchronized inputs, predicts the state and both enables on every clock, and the bench compares them with the outputs in that cycle. Zero-cross pulses placed inside and outside the blanking window separate R5 from R6.

// File: rtl/hb_pkg.sv
package hb_pkg;

    typedef enum logic [2:0] {
        ST_FAULT    = 3'd0,
        ST_DISABLED = 3'd1,
        ST_STANDBY  = 3'd2,
        ST_WAKING   = 3'd3,
        ST_FPWM     = 3'd4,
        ST_SKIP     = 3'd5
    } hb_state_t;

    localparam logic [1:0] LVL_LOW  = 2'b00;
    localparam logic [1:0] LVL_HIGH = 2'b10;

    function automatic logic lvl_is_mid(input logic [1:0] l);
        return (l != LVL_LOW) && (l != LVL_HIGH);
    endfunction

endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/hb_hold_timer.sv
module hb_hold_timer #(
    parameter int LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cond,
    output logic done
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cnt <= '0;
        else if (!cond)   cnt <= '0;
        else if (cnt != LIM) cnt <= cnt + 1'b1;
    end

    assign done = (cnt == LIM);
endmodule

// File: rtl/hb_gate_ctrl.sv
module hb_gate_ctrl #(
    parameter int DEAD_MIN_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_hs,
    input  logic req_ls,
    input  logic hs_off,
    input  logic ls_off,
    output logic hs_en,
    output logic ls_en
);
    logic both_low;
    logic dead_done;
    logic hs_en_n;
    logic ls_en_n;

    assign both_low = !hs_en && !ls_en;

    hb_hold_timer #(.LIMIT(DEAD_MIN_CYC)) u_dead (
        .clk  (clk),
        .rst_n(rst_n),
        .cond (both_low),
        .done (dead_done)
    );

    always_comb begin
        hs_en_n = req_hs && !req_ls && (hs_en || (!ls_en && ls_off && dead_done));
        ls_en_n = req_ls && !req_hs && (ls_en || (!hs_en && hs_off && dead_done));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hs_en <= 1'b0;
            ls_en <= 1'b0;
        end else begin
            hs_en <= hs_en_n;
            ls_en <= ls_en_n;
        end
    end

    // independent gap counter for the dead-time check
    localparam int GW = $clog2(DEAD_MIN_CYC + 2);
    logic [GW-1:0] gap_cnt;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gap_cnt <= GW'(DEAD_MIN_CYC);
        else if (hs_en || ls_en) gap_cnt <= '0;
        else if (gap_cnt < GW'(DEAD_MIN_CYC)) gap_cnt <= gap_cnt + 1'b1;
    end

    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_en && ls_en)); // R3
    AST_HS_AFTER_LS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_en) |-> $past(ls_off && !ls_en)); // R3
    AST_LS_AFTER_HS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ls_en) |-> $past(hs_off && !hs_en)); // R3
    AST_DEAD_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(hs_en) || $rose(ls_en)) |-> $past(gap_cnt) >= GW'(DEAD_MIN_CYC)); // R3
endmodule

// File: rtl/hb_phase_seq.sv
module hb_phase_seq
    import hb_pkg::*;
#(
    parameter int MID_HOLD_CYC = 32,
    parameter int SBY_HOLD_CYC = 100,
    parameter int ZC_BLANK_CYC = 44,
    parameter int DEAD_MIN_CYC = 2,
    parameter int WAKE_CYC     = 2500,
    parameter int SYNC_STAGES  = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] pwm_lvl,
    input  logic [1:0] mode_lvl,
    input  logic       hs_off_fb,
    input  logic       ls_off_fb,
    input  logic       zc_flag,
    input  logic       uv_flag,
    input  logic       ot_flag,
    output logic       hs_en,
    output logic       ls_en,
    output logic [2:0] state_o
);
    localparam int NIN  = 9;
    localparam int NTMR = 4;
    localparam int TMR_MID   = 0;
    localparam int TMR_SBY   = 1;
    localparam int TMR_BLANK = 2;
    localparam int TMR_WAKE  = 3;
    localparam int TMR_LIM [NTMR] = '{MID_HOLD_CYC, SBY_HOLD_CYC, ZC_BLANK_CYC, WAKE_CYC};
    // reset view: command and mode midlevel, faults asserted
    localparam logic [NIN-1:0] SYNC_RST = 9'b01_01_0_0_0_1_1;

    logic [NIN-1:0] raw_in, syn_in;
    logic [1:0] s_pwm, s_mode;
    logic s_hs_off, s_ls_off, s_zc, s_uv, s_ot;

    assign raw_in = {pwm_lvl, mode_lvl, hs_off_fb, ls_off_fb, zc_flag, uv_flag, ot_flag};

    hb_sync #(.W(NIN), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(raw_in), .q(syn_in)
    );

    assign {s_pwm, s_mode, s_hs_off, s_ls_off, s_zc, s_uv, s_ot} = syn_in;

    hb_state_t st, st_nx;
    logic pwm_hi, pwm_lo, pwm_mid, mode_hi, mode_lo, mode_mid, fault;
    logic skip_sel, skip_nx, cmd_hi_last, cmd_hi, zc_hit, zc_hit_nx;
    logic req_hs, req_ls;
    hb_state_t run_st;
    logic [NTMR-1:0] tmr_cond, tmr_done;

    assign pwm_hi   = (s_pwm == LVL_HIGH);
    assign pwm_lo   = (s_pwm == LVL_LOW);
    assign pwm_mid  = lvl_is_mid(s_pwm);
    assign mode_hi  = (s_mode == LVL_HIGH);
    assign mode_lo  = (s_mode == LVL_LOW);
    assign mode_mid = lvl_is_mid(s_mode);
    assign fault    = s_uv || s_ot;

    assign skip_nx = mode_lo ? 1'b1 : (mode_hi ? 1'b0 : skip_sel);
    assign run_st  = skip_nx ? ST_SKIP : ST_FPWM;
    assign cmd_hi  = pwm_hi || (pwm_mid && cmd_hi_last);

    assign tmr_cond[TMR_MID]   = pwm_mid;
    assign tmr_cond[TMR_SBY]   = mode_mid;
    assign tmr_cond[TMR_BLANK] = (st == ST_SKIP) && pwm_lo;
    assign tmr_cond[TMR_WAKE]  = (st == ST_WAKING);

    generate
        for (genvar k = 0; k < NTMR; k++) begin : g_tmr
            hb_hold_timer #(.LIMIT(TMR_LIM[k])) u_tmr (
                .clk(clk), .rst_n(rst_n), .cond(tmr_cond[k]), .done(tmr_done[k])
            );
        end
    endgenerate

    // next-state process
    always_comb begin
        st_nx = st;
        if (fault) begin
            st_nx = ST_FAULT;
        end else begin
            unique case (st)
                ST_FAULT:    st_nx = tmr_done[TMR_SBY] ? ST_STANDBY : run_st;
                ST_FPWM,
                ST_SKIP: begin
                    if (tmr_done[TMR_SBY])      st_nx = ST_STANDBY;
                    else if (tmr_done[TMR_MID]) st_nx = ST_DISABLED;
                    else                        st_nx = run_st;
                end
                ST_DISABLED: begin
                    if (tmr_done[TMR_SBY])      st_nx = ST_STANDBY;
                    else if (!pwm_mid)          st_nx = run_st;
                end
                ST_STANDBY:  if (!mode_mid && !pwm_mid) st_nx = ST_WAKING;
                ST_WAKING: begin
                    if (mode_mid)               st_nx = ST_STANDBY;
                    else if (tmr_done[TMR_WAKE]) st_nx = run_st;
                end
                default:     st_nx = ST_FAULT;
            endcase
        end
    end

    always_comb begin
        if (st != ST_SKIP || pwm_hi)                      zc_hit_nx = 1'b0;
        else if (pwm_lo && tmr_done[TMR_BLANK] && s_zc)   zc_hit_nx = 1'b1;
        else                                              zc_hit_nx = zc_hit;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st          <= ST_FAULT;
            skip_sel    <= 1'b0;
            cmd_hi_last <= 1'b0;
            zc_hit      <= 1'b0;
        end else begin
            st          <= st_nx;
            skip_sel    <= skip_nx;
            cmd_hi_last <= cmd_hi;
            zc_hit      <= zc_hit_nx;
        end
    end

    // output process
    always_comb begin
        req_hs = 1'b0;
        req_ls = 1'b0;
        unique case (st)
            ST_FPWM: begin
                req_hs = cmd_hi;
                req_ls = !cmd_hi;
            end
            ST_SKIP: begin
                req_hs = cmd_hi;
                req_ls = !cmd_hi && !zc_hit;
            end
            default: ;
        endcase
    end

    hb_gate_ctrl #(.DEAD_MIN_CYC(DEAD_MIN_CYC)) u_gate (
        .clk(clk), .rst_n(rst_n),
        .req_hs(req_hs), .req_ls(req_ls),
        .hs_off(s_hs_off), .ls_off(s_ls_off),
        .hs_en(hs_en), .ls_en(ls_en)
    );

    assign state_o = st;

    AST_FAULT_GATES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_FAULT) |=> (!hs_en && !ls_en)); // R9
    AST_STANDBY_GATES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_STANDBY) |=> (!hs_en && !ls_en)); // R7
    AST_WAKING_GATES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_WAKING) |=> (!hs_en && !ls_en)); // R8
    AST_DISABLED_GATES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DISABLED) |=> (!hs_en && !ls_en)); // R4
    AST_ZC_HOLDS_LS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SKIP && zc_hit && $past(zc_hit)) |-> !ls_en); // R5
    AST_FAULT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> (st == ST_FAULT)); // R9
endmodule

// File: tb/sim_hb_phase_seq.sv
module sim_hb_phase_seq;
    localparam int MIDC = 32, SBYC = 100, BLKC = 44, DEADC = 2, WAKEC = 2500;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [1:0] pwm_lvl = 2'b00, mode_lvl = 2'b10;
    logic hs_off_fb = 1'b1, ls_off_fb = 1'b1, zc_flag = 1'b0, uv_flag = 1'b0, ot_flag = 1'b0;
    logic hs_en, ls_en;
    logic [2:0] state_o;

    always #4 clk = ~clk;

    hb_phase_seq #(.MID_HOLD_CYC(MIDC), .SBY_HOLD_CYC(SBYC), .ZC_BLANK_CYC(BLKC),
                   .DEAD_MIN_CYC(DEADC), .WAKE_CYC(WAKEC), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst_n(rst_n), .pwm_lvl(pwm_lvl), .mode_lvl(mode_lvl),
        .hs_off_fb(hs_off_fb), .ls_off_fb(ls_off_fb), .zc_flag(zc_flag),
        .uv_flag(uv_flag), .ot_flag(ot_flag), .hs_en(hs_en), .ls_en(ls_en), .state_o(state_o)
    );

    int n_tests = 0, n_fail = 0;
    string cur_req = "R1";
    bit finished = 0;

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", rq, act, exp, $time);
        end
    endtask

    // gate feedback: reports off three cycles after the enable drops
    int hs_low_run = 3, ls_low_run = 3;
    always @(negedge clk) begin
        hs_low_run = hs_en ? 0 : hs_low_run + 1;
        ls_low_run = ls_en ? 0 : ls_low_run + 1;
        hs_off_fb = (hs_low_run >= 3);
        ls_off_fb = (ls_low_run >= 3);
    end

    // behavioural reference model
    int m_st, c_mid, c_sby, c_blk, c_wake, c_dead;
    bit m_skip, m_last, m_zc, m_hs, m_ls;
    int qa_pwm, qb_pwm, qa_mode, qb_mode;
    bit qa_hf, qb_hf, qa_lf, qb_lf, qa_zc, qb_zc, qa_ft, qb_ft;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st = 0; c_mid = 0; c_sby = 0; c_blk = 0; c_wake = 0; c_dead = 0;
            m_skip = 0; m_last = 0; m_zc = 0; m_hs = 0; m_ls = 0;
            qa_pwm = 1; qb_pwm = 1; qa_mode = 1; qb_mode = 1;
            qa_hf = 0; qb_hf = 0; qa_lf = 0; qb_lf = 0; qa_zc = 0; qb_zc = 0;
            qa_ft = 1; qb_ft = 1;
        end else begin
            bit phi, plo, pmid, mhi, mlo, mmid, skn, cmd, rh, rl, hs_n, ls_n, zc_n;
            int run, nst;
            phi = (qb_pwm == 2); plo = (qb_pwm == 0); pmid = !phi && !plo;
            mhi = (qb_mode == 2); mlo = (qb_mode == 0); mmid = !mhi && !mlo;
            skn = mlo ? 1'b1 : (mhi ? 1'b0 : m_skip);
            run = skn ? 5 : 4;
            cmd = phi || (pmid && m_last);
            rh = (m_st == 4 || m_st == 5) && cmd;
            rl = (m_st == 4 && !cmd) || (m_st == 5 && !cmd && !m_zc);
            hs_n = rh && !rl && (m_hs || (!m_ls && qb_lf && c_dead >= DEADC));
            ls_n = rl && !rh && (m_ls || (!m_hs && qb_hf && c_dead >= DEADC));
            nst = m_st;
            if (qb_ft) nst = 0;
            else if (m_st == 0) nst = (c_sby >= SBYC) ? 2 : run;
            else if (m_st == 4 || m_st == 5) nst = (c_sby >= SBYC) ? 2 : ((c_mid >= MIDC) ? 1 : run);
            else if (m_st == 1) begin
                if (c_sby >= SBYC) nst = 2; else if (!pmid) nst = run;
            end else if (m_st == 2) begin
                if (!mmid && !pmid) nst = 3;
            end else if (m_st == 3) begin
                if (mmid) nst = 2; else if (c_wake >= WAKEC) nst = run;
            end
            if (m_st != 5 || phi) zc_n = 0;
            else if (plo && c_blk >= BLKC && qb_zc) zc_n = 1;
            else zc_n = m_zc;
            c_mid  = pmid ? c_mid + 1 : 0;
            c_sby  = mmid ? c_sby + 1 : 0;
            c_blk  = (m_st == 5 && plo) ? c_blk + 1 : 0;
            c_wake = (m_st == 3) ? c_wake + 1 : 0;
            c_dead = (!m_hs && !m_ls) ? c_dead + 1 : 0;
            m_st = nst; m_skip = skn; m_last = cmd; m_zc = zc_n; m_hs = hs_n; m_ls = ls_n;
            qb_pwm = qa_pwm; qb_mode = qa_mode; qb_hf = qa_hf; qb_lf = qa_lf;
            qb_zc = qa_zc; qb_ft = qa_ft;
            qa_pwm = (pwm_lvl == 2'b00) ? 0 : ((pwm_lvl == 2'b10) ? 2 : 1);
            qa_mode = (mode_lvl == 2'b00) ? 0 : ((mode_lvl == 2'b10) ? 2 : 1);
            qa_hf = hs_off_fb; qa_lf = ls_off_fb; qa_zc = zc_flag; qa_ft = uv_flag || ot_flag;
        end
    end

    // per-cycle comparison and invariant checks
    int gap = 100;
    bit prev_hs = 0, prev_ls = 0;
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk(int'(state_o) == m_st && hs_en == m_hs && ls_en == m_ls, cur_req,
                int'({state_o, hs_en, ls_en}), (m_st << 2) | (int'(m_hs) << 1) | int'(m_ls));
            chk(!(hs_en && ls_en), "R3", int'({hs_en, ls_en}), 0);
            if ((hs_en && !prev_hs) || (ls_en && !prev_ls))
                chk(gap >= DEADC, "R3", gap, DEADC);
            gap = (!hs_en && !ls_en) ? gap + 1 : 0;
            prev_hs = hs_en; prev_ls = ls_en;
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        cyc(5);
        chk(!hs_en && !ls_en, "R1", int'({hs_en, ls_en}), 0);
        chk(state_o == 3'd0, "R1", int'(state_o), 0);
        rst_n = 1'b1;
        cur_req = "R9";
        cyc(30);
        chk(state_o == 3'd4, "R10", int'(state_o), 4);
        chk(ls_en && !hs_en, "R9", int'({hs_en, ls_en}), 1);

        cur_req = "R2";
        pwm_lvl = 2'b10; cyc(30);
        chk(hs_en && !ls_en, "R2", int'({hs_en, ls_en}), 2);
        pwm_lvl = 2'b00; cyc(30);
        chk(ls_en && !hs_en, "R2", int'({hs_en, ls_en}), 1);

        cur_req = "R4";
        pwm_lvl = 2'b01; cyc(20);
        chk(ls_en, "R4", int'(ls_en), 1);
        cyc(30);
        chk(state_o == 3'd1 && !hs_en && !ls_en, "R4", int'({state_o, hs_en, ls_en}), 4);
        pwm_lvl = 2'b10; cyc(3);
        chk(state_o == 3'd4, "R4", int'(state_o), 4);
        cyc(30);
        chk(hs_en, "R4", int'(hs_en), 1);
        pwm_lvl = 2'b11; cyc(60);
        chk(state_o == 3'd1, "R10", int'(state_o), 1);

        cur_req = "R6";
        mode_lvl = 2'b00; pwm_lvl = 2'b10; cyc(30);
        chk(state_o == 3'd5 && hs_en, "R10", int'({state_o, hs_en}), 11);
        pwm_lvl = 2'b00; zc_flag = 1'b1; cyc(20);
        chk(ls_en, "R6", int'(ls_en), 1);
        zc_flag = 1'b0;
        cur_req = "R5";
        cyc(40);
        chk(ls_en, "R5", int'(ls_en), 1);
        zc_flag = 1'b1; cyc(2); zc_flag = 1'b0; cyc(10);
        chk(!ls_en && !hs_en, "R5", int'({hs_en, ls_en}), 0);
        cyc(20);
        chk(!ls_en, "R5", int'(ls_en), 0);
        pwm_lvl = 2'b10; cyc(30);
        chk(hs_en, "R5", int'(hs_en), 1);
        pwm_lvl = 2'b00; cyc(30);
        chk(ls_en, "R5", int'(ls_en), 1);

        cur_req = "R7";
        mode_lvl = 2'b01; cyc(20);
        chk(state_o == 3'd5, "R7", int'(state_o), 5);
        cyc(100);
        chk(state_o == 3'd2 && !hs_en && !ls_en, "R7", int'({state_o, hs_en, ls_en}), 8);
        pwm_lvl = 2'b10; cyc(20);
        chk(state_o == 3'd2 && !hs_en, "R7", int'({state_o, hs_en}), 4);

        cur_req = "R8";
        mode_lvl = 2'b10; cyc(100);
        chk(state_o == 3'd3 && !hs_en && !ls_en, "R8", int'({state_o, hs_en, ls_en}), 12);
        cyc(2300);
        chk(state_o == 3'd3, "R8", int'(state_o), 3);
        cyc(200);
        chk(state_o == 3'd4 && hs_en, "R8", int'({state_o, hs_en}), 9);

        cur_req = "R9";
        pwm_lvl = 2'b00; cyc(30);
        uv_flag = 1'b1; cyc(6);
        chk(state_o == 3'd0 && !hs_en && !ls_en, "R9", int'({state_o, hs_en, ls_en}), 0);
        uv_flag = 1'b0; cyc(30);
        chk(ls_en && !hs_en, "R9", int'({hs_en, ls_en}), 1);
        pwm_lvl = 2'b10; cyc(30);
        ot_flag = 1'b1; cyc(6);
        chk(state_o == 3'd0 && !hs_en && !ls_en, "R9", int'({state_o, hs_en, ls_en}), 0);
        ot_flag = 1'b0; cyc(30);
        chk(hs_en, "R9", int'(hs_en), 1);

        // collisions: fault with a command edge, fault at standby expiry
        pwm_lvl = 2'b00; ot_flag = 1'b1; cyc(10);
        chk(!hs_en && !ls_en, "R9", int'({hs_en, ls_en}), 0);
        ot_flag = 1'b0; cyc(30);
        mode_lvl = 2'b01; cyc(SBYC + 2);
        uv_flag = 1'b1; cyc(10);
        chk(state_o == 3'd0, "R9", int'(state_o), 0);
        uv_flag = 1'b0; cyc(10);
        chk(state_o == 3'd2, "R7", int'(state_o), 2);
        cyc(5);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_tests++; n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule